// File: doc/BRIEF.md
# Coarse/Fine Segment Boundary Corrector

This block sits behind the encoder of a two-step folding converter. Near the edges between coarse segments, the coarse path and the fine path settle at different times. The coarse field can then name the segment next to the right one, while the fine field is still correct. The block takes the 3-bit coarse code, the 6-bit fine code and one fine-path comparator bit. The comparator bit reports the parity of the segment the fine path is folding in. The block returns a repaired 9-bit code.

In the first pipeline stage the block prepares a candidate coarse value one step away from the received one. The direction comes from the top bit of the fine field. A fine value in the lower half of its range means the coarse path lagged, so the candidate steps up. A fine value in the upper half means the coarse path ran ahead, so the candidate steps down. In the second stage, a single XOR of the coarse LSB and the comparator bit decides whether the candidate replaces the coarse field. The latency is a fixed two cycles and one sample is accepted every cycle.

Top module: `seg_boundary_fix`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_code` are cleared to 0 at that edge.
- R2: `out_valid` is high exactly two rising edges after a cycle in which `in_valid` was high, and low otherwise.
- R3: When `coarse_in[0]` equals `par_in`, `out_code` equals `{coarse_in, fine_in}` of the same sample.
- R4: `out_code[5:0]` always equals the `fine_in` of the same sample, whether or not a correction is made.
- R5: When `coarse_in[0]` differs from `par_in` and `fine_in[5]` is 0, the output coarse field `out_code[8:6]` is `coarse_in + 1`.
- R6: When `coarse_in[0]` differs from `par_in` and `fine_in[5]` is 1, the output coarse field is `coarse_in - 1`.
- R7: A correction saturates. A step up from coarse 7 leaves 7, and a step down from coarse 0 leaves 0. The output never wraps.
- R8: When a cycle with `in_valid` low follows, `out_code` holds its last value two edges later.
- R9: A coarse field that is off by one segment is repaired. The lag case has the fine field below 32 and the coarse field one low. The lead case has the fine field at 32 or above and the coarse field one high. In both cases the output equals the true 9-bit code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe for the inputs below |
| coarse_in | input | 3 | Coarse segment code from the encoder |
| fine_in | input | 6 | Fine code from the encoder |
| par_in | input | 1 | Fine-path comparator bit giving segment parity |
| out_valid | output | 1 | Strobe for `out_code` |
| out_code | output | 9 | Corrected code, coarse in bits 8:6 |

## Verification
Every result is due two rising edges after the edge that accepted the sample. The bench drives inputs on falling edges. It checks that `out_valid` is still low on the falling edge before the second edge and high just after it, and it samples the code there. Hold behaviour is checked several idle cycles later, without a new sample. The table vectors are built from a true code and an injected one-step coarse skew on each side of every inner segment boundary. The expected value is the true code, and the two outer boundaries are covered by directed saturation cases.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic {
    STEP_UP   = 1'b0,
    STEP_DOWN = 1'b1
  } step_dir_e;
endpackage

// File: rtl/sbc_candidate.sv
module sbc_candidate
  import sbc_pkg::*;
#(
  parameter int CW = 3,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [CW-1:0] coarse_in,
  input  logic [FW-1:0] fine_in,
  input  logic          par_in,
  output logic          s1_valid,
  output logic [CW-1:0] s1_coarse,
  output logic [FW-1:0] s1_fine,
  output logic [CW-1:0] s1_cand,
  output logic          s1_par
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  step_dir_e     dir;
  logic [CW-1:0] cand;

  always_comb begin
    dir = fine_in[FW-1] ? STEP_DOWN : STEP_UP;
    if (dir == STEP_UP) cand = (coarse_in == CMAX) ? coarse_in : coarse_in + 1'b1;
    else                cand = (coarse_in == '0)   ? coarse_in : coarse_in - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_coarse <= '0;
      s1_fine   <= '0;
      s1_cand   <= '0;
      s1_par    <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_coarse <= coarse_in;
        s1_fine   <= fine_in;
        s1_cand   <= cand;
        s1_par    <= par_in;
      end
    end
  end

  AST_CAND_ADJ: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> ((s1_cand == s1_coarse) || (s1_cand == s1_coarse + 1'b1) || (s1_cand == s1_coarse - 1'b1))) else $error("candidate not adjacent"); // R7
endmodule

// File: rtl/sbc_select.sv
module sbc_select #(
  parameter int CW = 3,
  parameter int FW = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s1_valid,
  input  logic [CW-1:0]    s1_coarse,
  input  logic [FW-1:0]    s1_fine,
  input  logic [CW-1:0]    s1_cand,
  input  logic             s1_par,
  output logic             out_valid,
  output logic [CW+FW-1:0] out_code
);
  logic mismatch;

  assign mismatch = s1_coarse[0] ^ s1_par;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_code <= mismatch ? {s1_cand, s1_fine} : {s1_coarse, s1_fine};
    end
  end

  AST_FINE_KEPT: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> (out_code[FW-1:0] == $past(s1_fine))) else $error("fine field altered"); // R4
endmodule

// File: rtl/seg_boundary_fix.sv
module seg_boundary_fix #(
  parameter int CW = 3,
  parameter int FW = 6,
  localparam int OW = CW + FW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [CW-1:0] coarse_in,
  input  logic [FW-1:0] fine_in,
  input  logic          par_in,
  output logic          out_valid,
  output logic [OW-1:0] out_code
);
  logic          s1_valid;
  logic [CW-1:0] s1_coarse;
  logic [FW-1:0] s1_fine;
  logic [CW-1:0] s1_cand;
  logic          s1_par;

  sbc_candidate #(.CW(CW), .FW(FW)) u_cand (
    .clk(clk), .rst(rst), .in_valid(in_valid), .coarse_in(coarse_in),
    .fine_in(fine_in), .par_in(par_in), .s1_valid(s1_valid),
    .s1_coarse(s1_coarse), .s1_fine(s1_fine), .s1_cand(s1_cand), .s1_par(s1_par)
  );

  sbc_select #(.CW(CW), .FW(FW)) u_sel (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_coarse(s1_coarse),
    .s1_fine(s1_fine), .s1_cand(s1_cand), .s1_par(s1_par),
    .out_valid(out_valid), .out_code(out_code)
  );

  // cycles since reset, saturating at 2, so two-deep history is trusted
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd2) warm <= warm + 1'b1;
  end

  AST_RESET_CLR: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_code == '0)) else $error("reset state"); // R1
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (out_valid == $past(in_valid, 2))) else $error("latency"); // R2
  AST_PASS: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && $past(in_valid, 2) && ($past(coarse_in[0], 2) == $past(par_in, 2)))
      |-> (out_code == {$past(coarse_in, 2), $past(fine_in, 2)})) else $error("pass-through"); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && !$past(in_valid, 2) && !$past(rst)) |-> $stable(out_code)) else $error("hold"); // R8
endmodule

// File: tb/tb_seg_boundary_fix.sv
module tb_seg_boundary_fix;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [2:0] coarse_in = '0;
  logic [5:0] fine_in = '0;
  logic       par_in = 1'b0;
  logic       out_valid;
  logic [8:0] out_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg_boundary_fix dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .coarse_in(coarse_in),
    .fine_in(fine_in), .par_in(par_in), .out_valid(out_valid), .out_code(out_code)
  );

  // {skew[1:0], true_code[8:0]}: skew 00 none, 01 coarse lags by one, 10 coarse leads by one
  localparam int NV = 18;
  localparam logic [10:0] VEC [0:NV-1] = '{
    {2'b01, 9'd67},  {2'b01, 9'd131}, {2'b01, 9'd195}, {2'b01, 9'd259},
    {2'b01, 9'd323}, {2'b01, 9'd387}, {2'b01, 9'd451},
    {2'b10, 9'd62},  {2'b10, 9'd126}, {2'b10, 9'd190}, {2'b10, 9'd254},
    {2'b10, 9'd318}, {2'b10, 9'd382}, {2'b10, 9'd446},
    {2'b00, 9'd0},   {2'b00, 9'd511}, {2'b00, 9'd63},  {2'b00, 9'd64}
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one sample, verify latency, sample result after the second edge
  task automatic apply(input string req, input logic [2:0] c, input logic [5:0] f,
                       input logic p, input logic [8:0] exp);
    @(negedge clk);
    in_valid = 1'b1; coarse_in = c; fine_in = f; par_in = p;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 early", {8'd0, out_valid}, 9'd0);
    @(posedge clk); #1;
    check("R2", {8'd0, out_valid}, 9'd1);
    check(req, out_code, exp);
    check("R4", {3'd0, out_code[5:0]}, {3'd0, f});
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", {8'd0, out_valid}, 9'd0);
    check("R1 code", out_code, 9'd0);
    rst = 1'b0;

    // table: skewed coarse around every inner boundary must give the true code (R9)
    for (int i = 0; i < NV; i++) begin
      logic [8:0] v;
      logic [2:0] c;
      v = VEC[i][8:0];
      c = v[8:6];
      if (VEC[i][10:9] == 2'b01) c = c - 3'd1;
      if (VEC[i][10:9] == 2'b10) c = c + 3'd1;
      apply("R9", c, v[5:0], v[6], v);
    end

    // R5 / R6 plain steps
    apply("R5", 3'd2, 6'd5, 1'b1, {3'd3, 6'd5});
    apply("R6", 3'd5, 6'd40, 1'b0, {3'd4, 6'd40});
    // R3 pass-through with parity agreeing in both halves
    apply("R3", 3'd6, 6'd33, 1'b0, {3'd6, 6'd33});
    apply("R3", 3'd3, 6'd1, 1'b1, {3'd3, 6'd1});
    // R7 saturation at both ends
    apply("R7 top", 3'd7, 6'd10, 1'b0, {3'd7, 6'd10});
    apply("R7 bottom", 3'd0, 6'd50, 1'b1, {3'd0, 6'd50});

    // R8 hold during idle, inputs toggled but not strobed
    apply("R8 setup", 3'd4, 6'd20, 1'b0, {3'd4, 6'd20});
    @(negedge clk);
    coarse_in = 3'd1; fine_in = 6'd60; par_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R8", out_code, {3'd4, 6'd20});
    check("R8 valid", {8'd0, out_valid}, 9'd0);

    // R1 reset mid-run clears state
    apply("R1 setup", 3'd5, 6'd7, 1'b1, {3'd5, 6'd7});
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 code", out_code, 9'd0);
    rst = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule